// File: doc/BRIEF.md
# I2C Slave Address-Match Receiver

This block is the receive half of an I2C slave. It runs on a fast system clock and oversamples the bus lines. It finds Start and Stop conditions and shifts in each byte, most significant bit first, on the rising edges of SCL. It compares the address byte against a host-written address register, then acknowledges or stays silent. An accepted byte is placed in a one-entry receive buffer, and a one-cycle interrupt pulse is sent to the host.

In ten-bit mode the block stops after each address byte. It holds SCL low and raises an update-address flag. The host then rewrites the address register: first with the low address byte, and after the low byte has matched, with the high byte again. Each write releases the clock. Once the full ten-bit address has matched, a Repeated Start followed by the high byte alone is enough to address the block again.

The block never drives either bus line high. Each output is an enable that pulls its line low.

Top module: `i2c_addr_slave`

## Requirements
- R1: A Start (SDA falling while SCL is high) moves the block to address reception. A Stop (SDA rising while SCL is high) returns it to idle and discards any partial ten-bit address progress, so the next high address byte again sets the update-address flag.
- R2: In seven-bit mode (`ten_bit`=0), the first byte after a Start matches when its bits [7:1] equal `addr_wdata`-loaded register bits [7:1]. Bit 0 is the read/write bit. On a match the block pulls SDA low through the whole ninth clock.
- R3: An accepted byte is copied into `rx_data`, `buf_full` is set, and `irq` pulses once after the ninth SCL falling edge.
- R4: If `buf_full` or `overrun` is already set when a matched byte completes, there is no ACK and `rx_data` is not loaded, but `irq` still pulses. If `buf_full` was set at that point, `overrun` becomes 1.
- R5: `buf_full` clears only on a `rx_read` pulse, and `overrun` clears only on an `ovr_clr` pulse.
- R6: With `se_irq_en`=1, every Start and every Stop also pulses `irq`. With it at 0, they do not.
- R7: After an address that does not match, the block gives no ACK and no `irq`, and it ignores every byte until the next Start.
- R8: In ten-bit mode the first byte matches only if it has the form 11110 A9 A8 0 and equals the address register. On a match the block sets `addr_upd` and pulls SCL low after the ninth falling edge, until the host writes the address register. That write clears `addr_upd` and releases SCL. A first byte ending in 1 is not acknowledged.
- R9: In ten-bit mode the second address byte is compared with all 8 bits of the address register. On a match it is acknowledged, `addr_upd` is set again and SCL is held low in the same way.
- R10: After a full ten-bit match, a Repeated Start followed by the matching high byte gives an ACK, loads the buffer, sets `buf_full` and pulses `irq`, without setting `addr_upd` or holding SCL.
- R11: Data bytes that follow a matched write address are loaded and acknowledged under the same rules as R3 and R4.
- R12: The block only pulls lines low. SDA is pulled low only during an ACK slot, and SCL is never pulled while SDA is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low (ACK) |
| ten_bit | input | 1 | 0 = seven-bit addressing, 1 = ten-bit addressing |
| se_irq_en | input | 1 | 1 adds interrupts on Start and Stop |
| addr_we | input | 1 | Write strobe for the address register |
| addr_wdata | input | 8 | Address register write data |
| rx_read | input | 1 | Host read strobe for the receive buffer |
| ovr_clr | input | 1 | Host clear strobe for the overrun flag |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | A byte arrived while the buffer was full |
| addr_upd | output | 1 | Ten-bit address register must be rewritten |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that SCL and SDA stay at each level for many system clocks longer than the two-flop synchronizer delay. They also assume that SDA changes only while SCL is low, except when it forms a Start or a Stop. The bench's bus master drives SDA while SCL is low and holds every SCL phase for 20 system clocks. It waits for SCL to actually rise before it continues, so a held clock simply stalls the master. Host strobes last one cycle and are issued only between bytes.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic       ten_bit,
  input  logic       se_irq_en,
  input  logic       addr_we,
  input  logic [7:0] addr_wdata,
  input  logic       rx_read,
  input  logic       ovr_clr,
  output logic [7:0] rx_data,
  output logic       buf_full,
  output logic       overrun,
  output logic       addr_upd,
  output logic       irq
);
  typedef enum logic [1:0] {IDLE, ADR, ADR_LO, DAT} ph_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [7:0] sr, adr;
  logic [3:0] cnt;
  ph_t        ph, nxt;
  logic       hit, want_upd, pend, pend_upd, hi_ok;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire rise  = scl_s & ~scl_d;
  wire fall  = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s; sda_d <= sda_s;
    end

  always_comb begin
    hit = 1'b0; want_upd = 1'b0; nxt = IDLE;
    case (ph)
      ADR:
        if (!ten_bit) begin
          hit = (sr[7:1] == adr[7:1]);
          nxt = sr[0] ? IDLE : DAT;
        end else if (sr[7:3] == 5'b11110 && sr[7:1] == adr[7:1]) begin
          if (hi_ok) begin
            hit = 1'b1; nxt = sr[0] ? IDLE : DAT;
          end else if (!sr[0]) begin
            hit = 1'b1; want_upd = 1'b1; nxt = ADR_LO;
          end
        end
      ADR_LO: if (sr == adr) begin hit = 1'b1; want_upd = 1'b1; nxt = DAT; end
      DAT: begin hit = 1'b1; nxt = DAT; end
      default: ;
    endcase
    if (!hit) nxt = IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; adr <= '0; cnt <= '0; ph <= IDLE;
      pend <= 1'b0; pend_upd <= 1'b0; hi_ok <= 1'b0;
      rx_data <= '0; buf_full <= 1'b0; overrun <= 1'b0; addr_upd <= 1'b0;
      scl_pull <= 1'b0; sda_pull <= 1'b0; irq <= 1'b0;
    end else begin
      if (rx_read) buf_full <= 1'b0;
      if (ovr_clr) overrun <= 1'b0;
      if (addr_we) begin
        adr <= addr_wdata; addr_upd <= 1'b0; scl_pull <= 1'b0;
      end
      irq <= 1'b0;
      if (start) begin
        ph <= ADR; cnt <= '0; sda_pull <= 1'b0; irq <= se_irq_en;
      end else if (stop) begin
        ph <= IDLE; cnt <= '0; sda_pull <= 1'b0; hi_ok <= 1'b0; irq <= se_irq_en;
      end else begin
        if (rise && cnt < 4'd8) begin
          sr  <= {sr[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (fall && cnt == 4'd8) begin
          cnt <= 4'd9; pend <= hit; pend_upd <= want_upd; ph <= nxt;
          if (!hit) hi_ok <= 1'b0;
          else if (ph == ADR_LO) hi_ok <= 1'b1;
          if (hit && !buf_full && !overrun) begin
            rx_data <= sr; buf_full <= 1'b1; sda_pull <= 1'b1;
          end else if (hit && buf_full) overrun <= 1'b1;
        end
        if (fall && cnt == 4'd9) begin
          cnt <= '0; sda_pull <= 1'b0; irq <= pend;
          if (pend && pend_upd) begin addr_upd <= 1'b1; scl_pull <= 1'b1; end
        end
      end
    end

  assert_ack_needs_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (!$past(buf_full) && !$past(overrun)));
  assert_overrun_from_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(buf_full));
  assert_buffer_moves_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $rose(buf_full));
  assert_hold_means_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> addr_upd);
  assert_one_line_pulled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_pull && scl_pull));
  assert_full_clears_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(rx_read));
endmodule

// File: tb/tb_i2c_addr_slave.sv
module tb_i2c_addr_slave;
  localparam int H = 20;
  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic ten_bit = 0, se_irq_en = 0, addr_we = 0, rx_read = 0, ovr_clr = 0;
  logic [7:0] addr_wdata = 0;
  logic scl_pull, sda_pull, buf_full, overrun, addr_upd, irq;
  logic [7:0] rx_data;
  int vectors = 0, errs = 0, irq_cnt = 0, n0;
  logic ack;

  wire scl = m_scl & ~scl_pull;
  wire sda = m_sda & ~sda_pull;

  always #5 clk = ~clk;

  i2c_addr_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .ten_bit(ten_bit), .se_irq_en(se_irq_en),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .rx_read(rx_read), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .buf_full(buf_full), .overrun(overrun), .addr_upd(addr_upd), .irq(irq));

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw; repeat (H) @(posedge clk); endtask

  task automatic do_start;
    m_sda = 1; hw; m_scl = 1; wait (scl); hw; m_sda = 0; hw; m_scl = 0; hw;
  endtask

  task automatic do_stop;
    m_sda = 0; hw; m_scl = 1; wait (scl); hw; m_sda = 1; hw;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw; m_scl = 1; wait (scl); hw; m_scl = 0; hw;
    end
    m_sda = 1; hw; m_scl = 1; wait (scl);
    repeat (H/2) @(posedge clk);
    @(negedge clk) a = !sda;
    repeat (H/2) @(posedge clk);
    m_scl = 0; hw;
    @(negedge clk);
  endtask

  task automatic strobe_read;
    @(negedge clk) rx_read = 1; @(negedge clk) rx_read = 0;
  endtask

  task automatic strobe_ovr;
    @(negedge clk) ovr_clr = 1; @(negedge clk) ovr_clr = 0;
  endtask

  task automatic write_addr(input logic [7:0] v);
    @(negedge clk) begin addr_we = 1; addr_wdata = v; end
    @(negedge clk) addr_we = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 reset sda_pull", sda_pull, 0);
    chk("R12 reset scl_pull", scl_pull, 0);
    chk("R5 reset buf_full", buf_full, 0);
    chk("R5 reset overrun", overrun, 0);
    chk("R8 reset addr_upd", addr_upd, 0);
    chk("R3 reset irq", irq_cnt, 0);
  endtask

  task automatic t_seven_bit;
    write_addr(8'hA4);
    n0 = irq_cnt;
    do_start;
    send_byte(8'hA4, ack);
    chk("R2 address ack", ack, 1);
    chk("R3 buffer loaded", rx_data, 8'hA4);
    chk("R3 buf_full set", buf_full, 1);
    chk("R3 irq on match", irq_cnt - n0, 1);
    send_byte(8'h3C, ack);
    chk("R11 data nack when full", ack, 0);
    chk("R4 overrun set", overrun, 1);
    chk("R4 buffer kept", rx_data, 8'hA4);
    chk("R4 irq still raised", irq_cnt - n0, 2);
    do_stop;
    chk("R6 no stop irq when disabled", irq_cnt - n0, 2);
  endtask

  task automatic t_flags;
    strobe_read;
    chk("R5 read clears buf_full", buf_full, 0);
    chk("R5 overrun survives read", overrun, 1);
    n0 = irq_cnt;
    do_start;
    send_byte(8'hA4, ack);
    chk("R4 nack on overrun alone", ack, 0);
    chk("R4 no load on overrun", buf_full, 0);
    chk("R4 irq on overrun alone", irq_cnt - n0, 1);
    do_stop;
    strobe_ovr;
    chk("R5 clear drops overrun", overrun, 0);
    do_start;
    send_byte(8'hA4, ack);
    chk("R2 ack after clear", ack, 1);
    strobe_read;
    send_byte(8'h7E, ack);
    chk("R11 data ack", ack, 1);
    chk("R11 data loaded", rx_data, 8'h7E);
    chk("R11 data buf_full", buf_full, 1);
    strobe_read;
    do_stop;
  endtask

  task automatic t_mismatch;
    n0 = irq_cnt;
    do_start;
    send_byte(8'h30, ack);
    chk("R7 no ack on mismatch", ack, 0);
    chk("R7 no irq on mismatch", irq_cnt - n0, 0);
    send_byte(8'hA4, ack);
    chk("R7 later byte ignored", ack, 0);
    chk("R7 buffer untouched", buf_full, 0);
    do_stop;
  endtask

  task automatic t_start_stop_irq;
    se_irq_en = 1;
    n0 = irq_cnt;
    do_start;
    chk("R6 start irq", irq_cnt - n0, 1);
    do_stop;
    chk("R6 stop irq", irq_cnt - n0, 2);
    se_irq_en = 0;
  endtask

  task automatic t_ten_bit;
    ten_bit = 1;
    write_addr(8'hF2);
    n0 = irq_cnt;
    do_start;
    send_byte(8'hF3, ack);
    chk("R8 read-form high byte rejected", ack, 0);
    chk("R8 no update flag on reject", addr_upd, 0);
    do_stop;
    do_start;
    send_byte(8'hF2, ack);
    chk("R8 high byte ack", ack, 1);
    chk("R8 update flag set", addr_upd, 1);
    chk("R8 SCL held", scl_pull, 1);
    chk("R8 irq on high byte", irq_cnt - n0, 1);
    strobe_read;
    write_addr(8'h9D);
    chk("R8 write clears flag", addr_upd, 0);
    chk("R8 write releases SCL", scl_pull, 0);
    send_byte(8'h9D, ack);
    chk("R9 low byte ack", ack, 1);
    chk("R9 low byte loaded", rx_data, 8'h9D);
    chk("R9 update flag again", addr_upd, 1);
    chk("R9 SCL held again", scl_pull, 1);
    strobe_read;
    write_addr(8'hF2);
    chk("R9 release after restore", scl_pull, 0);
    n0 = irq_cnt;
    do_start;
    send_byte(8'hF2, ack);
    chk("R10 repeated start ack", ack, 1);
    chk("R10 no update flag", addr_upd, 0);
    chk("R10 no SCL hold", scl_pull, 0);
    chk("R10 buf_full", buf_full, 1);
    chk("R10 irq", irq_cnt - n0, 1);
    strobe_read;
    send_byte(8'h11, ack);
    chk("R11 ten-bit data ack", ack, 1);
    chk("R11 ten-bit data loaded", rx_data, 8'h11);
    strobe_read;
    do_stop;
  endtask

  task automatic t_stop_discards;
    do_start;
    send_byte(8'hF2, ack);
    chk("R1 high byte after stop ack", ack, 1);
    chk("R1 stop discarded full match", addr_upd, 1);
    strobe_read;
    write_addr(8'hF2);
    do_stop;
    do_start;
    send_byte(8'h9D, ack);
    chk("R1 low byte alone rejected", ack, 0);
    do_stop;
    chk("R12 lines released", sda_pull | scl_pull, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (5) @(posedge clk);
    t_reset;
    t_seven_bit;
    t_flags;
    t_mismatch;
    t_start_stop_irq;
    t_ten_bit;
    t_stop_discards;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule